// File: doc/BRIEF.md
# Boot Block Top-Swap Address Remapper

This block sits on the address path of firmware-flash cycles that land near the top of a 32-bit address space. It lets firmware replace the boot block safely. Software first copies the boot block into the block just below it. It then turns on swapping, so that the topmost block and its lower neighbour trade places in the address map. While swapping is on, software can erase and rewrite the top block. If power fails during that rewrite, the machine still boots from the copy.

The remap inverts a single address bit. Its position comes from a 3-bit block-size code, and it applies only to addresses inside the top two blocks. A small control register holds a swap-enable bit, a sticky lock bit and the size code. The swap-enable bit lives in the battery-backed domain, so only the battery-well reset clears it. A board strap can force the effective enable on, and software cannot clear that forced value. The address path is purely combinational.

Top module: `tswap_remap_top`

## Requirements
- R1: The size code `cfg_wdata[4:2]` selects a block size of 64KB shifted left by the code (code 0 = 64KB up to code 7 = 8MB). The inverted address bit sits at position 16 plus the code.
- R2: While the effective enable is 1, the top block maps to the same offset in the block directly below it. An address in the top block is one in the range 0xFFFF_FFFF down to one block size below 2^32. The block below it maps back to the top block by the same rule.
- R3: While the effective enable is 0, `addr_out` equals `addr_in` for every address.
- R4: A low level on `bat_rst_n` clears the stored enable, the lock bit and the size code to 0. With the strap low, `cfg_rdata` then reads 0.
- R5: An address outside the top two blocks for the current size passes through unchanged, even with swapping enabled. This covers any address with one of bits 31..24 at 0.
- R6: While `strap_force` is 1, the effective enable is 1 and reads back as 1. A software write of 0 to the enable does not turn swapping off while the strap stays high.
- R7: Writing 1 to the lock bit (`cfg_wdata[1]`) sets it. Once the lock bit is set, writes to the enable and to the size code are ignored. Writes of 0 to the lock bit never clear it; only `bat_rst_n` does.
- R8: `plat_rst_n` resets none of the register state. While `plat_rst_n` is low, register writes are ignored.
- R9: An accepted register write becomes visible on `cfg_rdata` and in the address mapping at the clock edge that samples the write strobe, not before. `addr_out` follows `addr_in` with no clock delay.
- R10: `cfg_rdata` returns the effective enable in bit 0, the lock bit in bit 1 and the size code in bits 4:2. The effective enable is the stored enable ORed with the strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| bat_rst_n | input | 1 | Battery-well reset, asynchronous, active low |
| plat_rst_n | input | 1 | Platform reset, active low; blocks writes while asserted |
| strap_force | input | 1 | Board strap that forces the effective enable to 1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 5 | Write data: [0] enable, [1] lock, [4:2] size code |
| cfg_rdata | output | 5 | Read-back: [0] effective enable, [1] lock, [4:2] size code |
| addr_in | input | 32 | Incoming flash cycle address |
| addr_out | output | 32 | Remapped address |

## Verification
The bench sweeps all eight size codes. For each code it probes both edges of the top two blocks, one byte just below the window, and addresses with a high-order bit cleared. A design that used the wrong bit position, or a window off by one block, would remap the byte below the window or leave the edge of a block unmoved. Separate passes show several faults at the ports: a locked register that still accepts a new size, a lock that clears on a 0 write, a strap-forced enable that a 0 write turns off, and an enable lost across a platform reset. A final check confirms that a write becomes visible exactly one edge after the strobe.

// File: rtl/tswap_pkg.sv
package tswap_pkg;

  localparam int unsigned TS_ADDR_W   = 32;
  localparam int unsigned TS_SIZE_W   = 3;
  localparam int unsigned TS_BASE_BIT = 16;
  localparam int unsigned TS_CFG_W    = TS_SIZE_W + 2;

  // Control register layout: size in the high bits, lock, then enable in bit 0
  typedef struct packed {
    logic [TS_SIZE_W-1:0] size;
    logic                 lock;
    logic                 en;
  } tswap_cfg_t;

  // Position of the address bit that is inverted for a size code
  function automatic int unsigned flip_pos(input int unsigned base_bit,
                                           input int unsigned code);
    return base_bit + code;
  endfunction

  // Build a one-hot mask for a bit position
  function automatic logic [TS_ADDR_W-1:0] bit_mask(input int unsigned pos);
    logic [TS_ADDR_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  // Next value of the stored configuration for one accepted write
  function automatic tswap_cfg_t cfg_next(input tswap_cfg_t cur,
                                          input tswap_cfg_t wr);
    tswap_cfg_t n;
    n      = cur;
    n.lock = cur.lock | wr.lock;
    if (!cur.lock) begin
      n.en   = wr.en;
      n.size = wr.size;
    end
    return n;
  endfunction

endpackage

// File: rtl/tswap_ctrl_reg.sv
module tswap_ctrl_reg
  import tswap_pkg::*;
(
  input  logic       clk,
  input  logic       bat_rst_n,
  input  logic       plat_rst_n,
  input  logic       strap_force,
  input  logic       cfg_we,
  input  tswap_cfg_t cfg_wr,
  output tswap_cfg_t cfg_q,
  output logic       eff_en,
  output logic       wr_accept
);

  tswap_cfg_t cfg_d;

  // Writes are accepted only while the platform is out of reset
  assign wr_accept = cfg_we & plat_rst_n;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_accept) begin
      cfg_d = cfg_next(cfg_q, cfg_wr);
    end
  end

  // Battery-well domain: only bat_rst_n clears this state
  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign eff_en = cfg_q.en | strap_force;

endmodule

// File: rtl/tswap_addr_xlate.sv
module tswap_addr_xlate #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned BASE_BIT = 16
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              eff_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic              win_hit,
  output logic              swap_active
);

  localparam int unsigned NCODES = 1 << SIZE_W;

  logic [NCODES-1:0] hit_vec;
  logic [ADDR_W-1:0] mask_arr [NCODES];

  // One window decoder per size code; the code selects among them
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int unsigned FP = BASE_BIT + c;
    assign hit_vec[c]  = &addr_in[ADDR_W-1:FP+1];
    assign mask_arr[c] = tswap_pkg::bit_mask(tswap_pkg::flip_pos(BASE_BIT, c));
  end

  assign win_hit     = hit_vec[size_code];
  assign swap_active = eff_en & win_hit;
  assign addr_out    = swap_active ? (addr_in ^ mask_arr[size_code]) : addr_in;

endmodule

// File: rtl/tswap_remap_top.sv
module tswap_remap_top
  import tswap_pkg::*;
(
  input  logic                 clk,
  input  logic                 bat_rst_n,
  input  logic                 plat_rst_n,
  input  logic                 strap_force,
  input  logic                 cfg_we,
  input  logic [TS_CFG_W-1:0]  cfg_wdata,
  output logic [TS_CFG_W-1:0]  cfg_rdata,
  input  logic [TS_ADDR_W-1:0] addr_in,
  output logic [TS_ADDR_W-1:0] addr_out
);

  tswap_cfg_t cfg_wr;
  tswap_cfg_t cfg_q;
  logic       eff_en;
  logic       wr_accept;
  logic       win_hit;
  logic       swap_active;

  assign cfg_wr = tswap_cfg_t'(cfg_wdata);

  tswap_ctrl_reg u_reg (
    .clk         (clk),
    .bat_rst_n   (bat_rst_n),
    .plat_rst_n  (plat_rst_n),
    .strap_force (strap_force),
    .cfg_we      (cfg_we),
    .cfg_wr      (cfg_wr),
    .cfg_q       (cfg_q),
    .eff_en      (eff_en),
    .wr_accept   (wr_accept)
  );

  tswap_addr_xlate #(
    .ADDR_W   (TS_ADDR_W),
    .SIZE_W   (TS_SIZE_W),
    .BASE_BIT (TS_BASE_BIT)
  ) u_xlate (
    .addr_in     (addr_in),
    .size_code   (cfg_q.size),
    .eff_en      (eff_en),
    .addr_out    (addr_out),
    .win_hit     (win_hit),
    .swap_active (swap_active)
  );

  assign cfg_rdata = {cfg_q.size, cfg_q.lock, eff_en};

endmodule

// File: rtl/tswap_remap_chk.sv
module tswap_remap_chk
  import tswap_pkg::*;
(
  input logic                 clk,
  input logic                 bat_rst_n,
  input logic                 plat_rst_n,
  input logic                 strap_force,
  input logic [TS_CFG_W-1:0]  cfg_rdata,
  input logic [TS_ADDR_W-1:0] addr_in,
  input logic [TS_ADDR_W-1:0] addr_out,
  input logic                 win_hit,
  input logic                 swap_active,
  input logic                 en_q,
  input logic                 lock_q,
  input logic [TS_SIZE_W-1:0] size_q
);

  p_passthru_off_r3: assert property (@(posedge clk) disable iff (!bat_rst_n)
    !cfg_rdata[0] |-> (addr_out == addr_in));

  p_outside_window_r5: assert property (@(posedge clk) disable iff (!bat_rst_n)
    !win_hit |-> (addr_out == addr_in));

  p_single_flip_r2: assert property (@(posedge clk) disable iff (!bat_rst_n)
    swap_active |-> ($countones(addr_out ^ addr_in) == 1));

  p_strap_forces_r6: assert property (@(posedge clk) disable iff (!bat_rst_n)
    strap_force |-> cfg_rdata[0]);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!bat_rst_n)
    lock_q |=> lock_q);

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!bat_rst_n)
    lock_q |=> ($stable(size_q) && $stable(en_q)));

  p_plat_rst_hold_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
    !plat_rst_n |=> ($stable(size_q) && $stable(en_q) && $stable(lock_q)));

endmodule

bind tswap_remap_top tswap_remap_chk chk_i (
  .clk         (clk),
  .bat_rst_n   (bat_rst_n),
  .plat_rst_n  (plat_rst_n),
  .strap_force (strap_force),
  .cfg_rdata   (cfg_rdata),
  .addr_in     (addr_in),
  .addr_out    (addr_out),
  .win_hit     (win_hit),
  .swap_active (swap_active),
  .en_q        (cfg_q.en),
  .lock_q      (cfg_q.lock),
  .size_q      (cfg_q.size)
);

// File: tb/tswap_remap_top_tb_top.sv
module tswap_remap_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        bat_rst_n = 1'b0;
  logic        plat_rst_n = 1'b0;
  logic        strap_force = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic [31:0] addr_in = '0;
  logic [31:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tswap_remap_top dut_i (
    .clk         (clk),
    .bat_rst_n   (bat_rst_n),
    .plat_rst_n  (plat_rst_n),
    .strap_force (strap_force),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .addr_in     (addr_in),
    .addr_out    (addr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sz, input logic lk, input logic en);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {sz, lk, en};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Expected mapping restated arithmetically from block size
  function automatic logic [31:0] model(input logic [31:0] a, input int sz, input bit en);
    longint blk, top_base, low_base, x;
    blk      = longint'(64'd1) << (16 + sz);
    top_base = (longint'(64'd1) << 32) - blk;
    low_base = top_base - blk;
    x = longint'(a);
    if (!en) return a;
    if (x >= top_base) return 32'(x - blk);
    if (x >= low_base) return 32'(x + blk);
    return a;
  endfunction

  task automatic probe(input string req, input logic [31:0] a, input int sz, input bit en);
    addr_in = a;
    #1;
    check(req, addr_out, model(a, sz, en));
  endtask

  task automatic sweep(input string req, input int sz, input bit en);
    logic [31:0] blk, tb, lb;
    blk = 32'd1 << (16 + sz);
    tb  = 32'd0 - blk;
    lb  = tb - blk;
    probe(req, tb, sz, en);
    probe(req, tb + 32'h1234, sz, en);
    probe(req, 32'hFFFF_FFFF, sz, en);
    probe(req, lb, sz, en);
    probe(req, lb + blk - 1, sz, en);
    probe({req, "/R5"}, lb - 1, sz, en);
    probe({req, "/R5"}, tb ^ 32'h8000_0000, sz, en);
    probe({req, "/R5"}, tb ^ 32'h0100_0000, sz, en);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    bat_rst_n  = 1'b1;
    plat_rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state reads back all zero
    check("R4 reset readback", {27'd0, cfg_rdata}, 32'd0);
    // R3: disabled path is transparent
    probe("R3 reset passthru", 32'hFFFF_0010, 0, 1'b0);

    // R1/R2/R5/R10: all size codes with swapping on
    for (int s = 0; s < 8; s++) begin
      do_write(3'(s), 1'b0, 1'b1);
      check("R10 R1 readback", {27'd0, cfg_rdata}, {27'd0, 3'(s), 2'b01});
      sweep("R1 R2 swap", s, 1'b1);
      do_write(3'(s), 1'b0, 1'b0);
      sweep("R3 disabled", s, 1'b0);
    end

    // R9: write visible only after the strobing edge
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {3'd2, 1'b0, 1'b1};
    #1;
    check("R9 before edge", {27'd0, cfg_rdata}, {27'd0, 3'd7, 2'b00});
    probe("R9 before edge addr", 32'hFFFC_0000, 2, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 after edge", {27'd0, cfg_rdata}, {27'd0, 3'd2, 2'b01});
    probe("R9 after edge addr", 32'hFFFC_0000, 2, 1'b1);

    // R8: platform reset keeps state, blocks writes
    @(negedge clk);
    plat_rst_n = 1'b0;
    do_write(3'd6, 1'b1, 1'b0);
    check("R8 write blocked", {27'd0, cfg_rdata}, {27'd0, 3'd2, 2'b01});
    @(negedge clk);
    plat_rst_n = 1'b1;
    @(negedge clk);
    check("R8 state kept", {27'd0, cfg_rdata}, {27'd0, 3'd2, 2'b01});

    // R6: strap forces enable
    do_write(3'd1, 1'b0, 1'b0);
    strap_force = 1'b1;
    #1;
    check("R6 strap readback", {27'd0, cfg_rdata}, {27'd0, 3'd1, 2'b01});
    probe("R6 strap swap", 32'hFFFE_0044, 1, 1'b1);
    do_write(3'd1, 1'b0, 1'b0);
    check("R6 zero write ignored", {31'd0, cfg_rdata[0]}, 32'd1);
    probe("R6 still swapping", 32'hFFFC_0044, 1, 1'b1);
    strap_force = 1'b0;
    #1;
    check("R6 strap released", {27'd0, cfg_rdata}, {27'd0, 3'd1, 2'b00});

    // R7: lock freezes enable and size, and cannot be cleared
    do_write(3'd5, 1'b1, 1'b1);
    check("R7 lock set", {27'd0, cfg_rdata}, {27'd0, 3'd5, 2'b11});
    do_write(3'd0, 1'b0, 1'b0);
    check("R7 locked hold", {27'd0, cfg_rdata}, {27'd0, 3'd5, 2'b11});
    sweep("R7 locked map", 5, 1'b1);
    do_write(3'd3, 1'b1, 1'b0);
    check("R7 locked hold2", {27'd0, cfg_rdata}, {27'd0, 3'd5, 2'b11});

    // R4: battery reset clears everything
    @(negedge clk);
    bat_rst_n = 1'b0;
    #1;
    check("R4 battery reset", {27'd0, cfg_rdata}, 32'd0);
    @(negedge clk);
    bat_rst_n = 1'b1;
    do_write(3'd4, 1'b0, 1'b1);
    check("R4 unlocked after reset", {27'd0, cfg_rdata}, {27'd0, 3'd4, 2'b01});

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule